// File: doc/BRIEF.md
# Call-Frame Stack Controller

This block tracks the three register-window pointers an instruction sequencer needs: the frame being built for an upcoming callee (OPEN), the frame of the running routine (ACTIVE) and the caller's frame (RETURN). Every issued instruction carries a 3-bit call operation. When `step` is high the block applies that operation at the rising clock edge. It can allocate a fresh frame, activate the open frame while saving the caller's context, or unwind back to the caller. The three pointers drive register address bits 11..4, so each frame holds sixteen registers.

A call pushes a pair onto an internal return stack of parameterised depth: the caller's RETURN pointer and the current PC plus one. A return pops that pair, restores the pointers and presents the saved PC on `ret_pc` for the sequencer. Frame numbers come from an in-use map, and allocation always takes the lowest free number. A push into a full stack, or an allocation with no free frame, sets a sticky overflow flag. A return from an empty stack sets a sticky underflow flag. In both cases all pointers are left untouched. Spilling to memory is not part of this block.

Top module: `cfs_ctrl`

## Requirements
- R1: After reset, OPEN, ACTIVE and RETURN are 0, `ret_pc` is 0, both flags are low, the return stack is empty and frame 0 is the only frame in use.
- R2: Operation code 1 (open) loads OPEN with the lowest-numbered free frame and marks it in use. ACTIVE and RETURN do not change.
- R3: Operation code 4 (call) pushes {RETURN, `cur_pc`+1}, sets RETURN to the old ACTIVE and sets ACTIVE to OPEN. OPEN keeps its value.
- R4: Operation code 7 (return) sets ACTIVE and OPEN to the old RETURN, pops the top entry into RETURN, and drives its saved PC onto `ret_pc`.
- R5: Operation code 5 (open-and-call) makes all three moves in one cycle: the push as in R3, RETURN to old ACTIVE, ACTIVE to old OPEN, and OPEN to the lowest free frame.
- R6: Operation code 2 (tail open) copies ACTIVE into OPEN without allocating a frame. ACTIVE, RETURN and the stack do not change.
- R7: Operation code 6 (tail call) copies OPEN into ACTIVE. RETURN and the stack do not change.
- R8: A replaced OPEN frame is released on open, tail open or return, unless it equals the old ACTIVE or RETURN. A left ACTIVE frame is released on a tail call unless it equals OPEN or RETURN, and on a return unless it equals RETURN. A released frame is eligible for allocation in the next cycle.
- R9: Codes 0 and 3 change nothing, and with `step` low any code changes nothing.
- R10: A call or open-and-call with a full stack, or an open or open-and-call with no free frame, sets `ovf_flag`. The flag stays set until reset, and the pointers, `ret_pc` and the stack stay as they were.
- R11: A return with an empty stack sets `unf_flag`. The flag stays set until reset, and the pointers and `ret_pc` stay as they were.
- R12: The saved return address is `cur_pc`+1 modulo 2^PC_W, so a call at the all-ones PC returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with `clk` |
| step | input | 1 | Instruction issues this cycle; enables the operation |
| chop | input | 3 | Call operation code (0 nop, 1 open, 2 tail open, 3 spare, 4 call, 5 open-and-call, 6 tail call, 7 return) |
| cur_pc | input | PC_W | PC of the issuing instruction |
| open_fp | output | FRAME_W | OPEN frame pointer |
| active_fp | output | FRAME_W | ACTIVE frame pointer |
| return_fp | output | FRAME_W | RETURN frame pointer |
| ret_pc | output | PC_W | Return PC from the most recent return |
| ovf_flag | output | 1 | Sticky overflow flag |
| unf_flag | output | 1 | Sticky underflow flag |

## Verification
The assertions take for granted that `rst_n` is already synchronised to `clk` and that `step` and `chop` are settled before each rising edge. The bench drives every input on the falling edge and lowers `step` one time unit after the rising edge, so each operation is seen exactly once. The stack-level signal the checker reads is internal, so the checker depends on that level only moving on a push or a pop. The stimulus builds small frame and PC spaces so that frame exhaustion, a full stack and PC wrap-around can all be reached in a short run.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  typedef enum logic [2:0] {
    CH_NOP   = 3'd0,
    CH_OPEN  = 3'd1,
    CH_TOPEN = 3'd2,
    CH_SPARE = 3'd3,
    CH_CALL  = 3'd4,
    CH_OCALL = 3'd5,
    CH_TCALL = 3'd6,
    CH_RET   = 3'd7
  } chop_e;
endpackage

// File: rtl/cfs_frame_alloc.sv
module cfs_frame_alloc #(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic               give_a,
  input  logic [FRAME_W-1:0] give_a_id,
  input  logic               give_b,
  input  logic [FRAME_W-1:0] give_b_id,
  output logic [FRAME_W-1:0] free_id,
  output logic               any_free
);
  localparam int NF = 1 << FRAME_W;

  logic [NF-1:0] used_q, used_d;
  logic          upd;

  // lowest-numbered free frame
  always_comb begin
    free_id  = '0;
    any_free = 1'b0;
    for (int i = NF - 1; i >= 0; i--) begin
      if (!used_q[i]) begin
        free_id  = FRAME_W'(i);
        any_free = 1'b1;
      end
    end
  end

  always_comb begin
    used_d = used_q;
    if (give_a) used_d[give_a_id] = 1'b0;
    if (give_b) used_d[give_b_id] = 1'b0;
    if (take)   used_d[free_id]   = 1'b1;
  end

  assign upd = take | give_a | give_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= NF'(1);
    end else if (upd) begin
      used_q <= used_d;
    end
  end
endmodule

// File: rtl/cfs_ret_stack.sv
module cfs_ret_stack #(
  parameter int DEPTH = 8,
  parameter int ENT_W = 32,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [ENT_W-1:0] push_data,
  output logic [ENT_W-1:0] top_data,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [LVL_W-1:0] level_q, level_d;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [ENT_W-1:0] rd_arr [DEPTH];

  assign wr_idx = level_q[IDX_W-1:0];
  assign rd_idx = IDX_W'(level_q - LVL_W'(1));
  assign full   = (level_q == LVL_W'(DEPTH));
  assign empty  = (level_q == '0);
  assign level  = level_q;

  always_comb begin
    level_d = level_q;
    if (push && !full)       level_d = level_q + LVL_W'(1);
    else if (pop && !empty)  level_d = level_q - LVL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
    end else if (push || pop) begin
      level_q <= level_d;
    end
  end

  // one storage register per stack slot
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [ENT_W-1:0] ent_q;
    logic             wr_en;
    assign wr_en = push && !full && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (wr_en) ent_q <= push_data;
    end
    assign rd_arr[g] = ent_q;
  end

  assign top_data = rd_arr[rd_idx];
endmodule

// File: rtl/cfs_ctrl.sv
module cfs_ctrl #(
  parameter int FRAME_W = 8,
  parameter int PC_W    = 24,
  parameter int DEPTH   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  input  logic [2:0]         chop,
  input  logic [PC_W-1:0]    cur_pc,
  output logic [FRAME_W-1:0] open_fp,
  output logic [FRAME_W-1:0] active_fp,
  output logic [FRAME_W-1:0] return_fp,
  output logic [PC_W-1:0]    ret_pc,
  output logic               ovf_flag,
  output logic               unf_flag
);
  import cfs_pkg::*;

  localparam int ENT_W = FRAME_W + PC_W;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [FRAME_W-1:0] open_q, open_d, act_q, act_d, ret_q, ret_d;
  logic [PC_W-1:0]    rpc_q, rpc_d, pc_inc;
  logic               ovf_q, ovf_d, unf_q, unf_d;

  logic               push, pop, take, give_a, give_b;
  logic [FRAME_W-1:0] give_a_id, give_b_id, free_id;
  logic               any_free, stk_full, stk_empty;
  logic [ENT_W-1:0]   top_data;
  logic [LVL_W-1:0]   stk_lvl;
  logic [FRAME_W-1:0] top_fp;
  logic [PC_W-1:0]    top_pc;
  logic               open_spare;
  chop_e              op;

  assign op         = chop_e'(chop);
  assign pc_inc     = cur_pc + PC_W'(1);
  assign top_fp     = top_data[ENT_W-1 -: FRAME_W];
  assign top_pc     = top_data[PC_W-1:0];
  // uncalled open frame that nobody else names
  assign open_spare = (open_q != act_q) && (open_q != ret_q);

  cfs_frame_alloc #(.FRAME_W(FRAME_W)) u_alloc (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .give_a    (give_a),
    .give_a_id (give_a_id),
    .give_b    (give_b),
    .give_b_id (give_b_id),
    .free_id   (free_id),
    .any_free  (any_free)
  );

  cfs_ret_stack #(.DEPTH(DEPTH), .ENT_W(ENT_W), .LVL_W(LVL_W)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .pop       (pop),
    .push_data ({ret_q, pc_inc}),
    .top_data  (top_data),
    .level     (stk_lvl),
    .full      (stk_full),
    .empty     (stk_empty)
  );

  // next-state
  always_comb begin
    open_d    = open_q;
    act_d     = act_q;
    ret_d     = ret_q;
    rpc_d     = rpc_q;
    ovf_d     = ovf_q;
    unf_d     = unf_q;
    push      = 1'b0;
    pop       = 1'b0;
    take      = 1'b0;
    give_a    = 1'b0;
    give_a_id = open_q;
    give_b    = 1'b0;
    give_b_id = open_q;
    if (step) begin
      unique case (op)
        CH_OPEN: begin
          if (!any_free) begin
            ovf_d = 1'b1;
          end else begin
            take   = 1'b1;
            open_d = free_id;
            give_a = open_spare;
          end
        end
        CH_TOPEN: begin
          open_d = act_q;
          give_a = open_spare;
        end
        CH_CALL: begin
          if (stk_full) begin
            ovf_d = 1'b1;
          end else begin
            push  = 1'b1;
            ret_d = act_q;
            act_d = open_q;
          end
        end
        CH_OCALL: begin
          if (stk_full || !any_free) begin
            ovf_d = 1'b1;
          end else begin
            push   = 1'b1;
            take   = 1'b1;
            ret_d  = act_q;
            act_d  = open_q;
            open_d = free_id;
          end
        end
        CH_TCALL: begin
          act_d     = open_q;
          give_a    = (act_q != open_q) && (act_q != ret_q);
          give_a_id = act_q;
        end
        CH_RET: begin
          if (stk_empty) begin
            unf_d = 1'b1;
          end else begin
            pop       = 1'b1;
            act_d     = ret_q;
            open_d    = ret_q;
            ret_d     = top_fp;
            rpc_d     = top_pc;
            give_a    = (act_q != ret_q);
            give_a_id = act_q;
            give_b    = open_spare;
            give_b_id = open_q;
          end
        end
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= '0;
      act_q  <= '0;
      ret_q  <= '0;
      rpc_q  <= '0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else if (step) begin
      open_q <= open_d;
      act_q  <= act_d;
      ret_q  <= ret_d;
      rpc_q  <= rpc_d;
      ovf_q  <= ovf_d;
      unf_q  <= unf_d;
    end
  end

  assign open_fp   = open_q;
  assign active_fp = act_q;
  assign return_fp = ret_q;
  assign ret_pc    = rpc_q;
  assign ovf_flag  = ovf_q;
  assign unf_flag  = unf_q;
endmodule

// File: rtl/cfs_ctrl_chk.sv
module cfs_ctrl_chk #(
  parameter int FRAME_W = 8,
  parameter int PC_W    = 24,
  parameter int DEPTH   = 8,
  parameter int LVL_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               step,
  input logic [2:0]         chop,
  input logic [FRAME_W-1:0] open_fp,
  input logic [FRAME_W-1:0] active_fp,
  input logic [FRAME_W-1:0] return_fp,
  input logic [PC_W-1:0]    ret_pc,
  input logic               ovf_flag,
  input logic               unf_flag,
  input logic [LVL_W-1:0]   lvl
);
  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);

  // R11
  unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_flag |=> unf_flag);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step || chop == 3'd0 || chop == 3'd3) |=>
      ($stable(open_fp) && $stable(active_fp) && $stable(return_fp) && $stable(ret_pc)));

  // R3
  call_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && chop == 3'd4 && lvl < LVL_W'(DEPTH)) |=>
      (active_fp == $past(open_fp) && return_fp == $past(active_fp) && lvl == $past(lvl) + LVL_W'(1)));

  // R11
  unf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && chop == 3'd7 && lvl == '0) |=>
      (unf_flag && $stable(active_fp) && $stable(return_fp) && $stable(open_fp)));

  // R6
  topen_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && chop == 3'd2) |=> (open_fp == $past(active_fp) && $stable(active_fp) && $stable(return_fp)));

  // R7
  tcall_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && chop == 3'd6) |=> (active_fp == $past(open_fp) && $stable(return_fp) && $stable(lvl)));
endmodule

bind cfs_ctrl cfs_ctrl_chk #(
  .FRAME_W(FRAME_W), .PC_W(PC_W), .DEPTH(DEPTH), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .chop(chop),
  .open_fp(open_fp), .active_fp(active_fp), .return_fp(return_fp),
  .ret_pc(ret_pc), .ovf_flag(ovf_flag), .unf_flag(unf_flag), .lvl(stk_lvl)
);

// File: tb/tb_cfs_ctrl.sv
module tb_cfs_ctrl;
  localparam int FW = 3;
  localparam int PW = 8;
  localparam int DP = 8;
  localparam int NF = 1 << FW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          step = 1'b0;
  logic [2:0]    chop = 3'd0;
  logic [PW-1:0] cur_pc = '0;
  logic [FW-1:0] open_fp, active_fp, return_fp;
  logic [PW-1:0] ret_pc;
  logic          ovf_flag, unf_flag;

  always #2 clk = ~clk;

  cfs_ctrl #(.FRAME_W(FW), .PC_W(PW), .DEPTH(DP)) dut (
    .clk(clk), .rst_n(rst_n), .step(step), .chop(chop), .cur_pc(cur_pc),
    .open_fp(open_fp), .active_fp(active_fp), .return_fp(return_fp),
    .ret_pc(ret_pc), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  typedef struct {
    int            due;
    logic [FW-1:0] o, a, r;
    logic [PW-1:0] pc;
    logic          ov, un;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;

  // reference model
  int            m_o, m_a, m_r, m_lvl;
  logic [PW-1:0] m_rpc;
  bit            m_ovf, m_unf;
  bit            m_used [NF];
  int            m_sfp [DP];
  logic [PW-1:0] m_spc [DP];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic model_reset();
    m_o = 0; m_a = 0; m_r = 0; m_lvl = 0; m_rpc = '0; m_ovf = 0; m_unf = 0;
    for (int i = 0; i < NF; i++) m_used[i] = (i == 0);
  endtask

  task automatic model_step(input logic [2:0] c, input logic [PW-1:0] pc);
    int f;
    f = -1;
    for (int i = NF - 1; i >= 0; i--) if (!m_used[i]) f = i;
    case (c)
      3'd1: if (f < 0) m_ovf = 1; else begin
              if (m_o != m_a && m_o != m_r) m_used[m_o] = 0;
              m_used[f] = 1; m_o = f;
            end
      3'd2: begin
              if (m_o != m_a && m_o != m_r) m_used[m_o] = 0;
              m_o = m_a;
            end
      3'd4: if (m_lvl == DP) m_ovf = 1; else begin
              m_sfp[m_lvl] = m_r; m_spc[m_lvl] = pc + 8'd1; m_lvl++;
              m_r = m_a; m_a = m_o;
            end
      3'd5: if (m_lvl == DP || f < 0) m_ovf = 1; else begin
              m_sfp[m_lvl] = m_r; m_spc[m_lvl] = pc + 8'd1; m_lvl++;
              m_r = m_a; m_a = m_o; m_used[f] = 1; m_o = f;
            end
      3'd6: begin
              if (m_a != m_o && m_a != m_r) m_used[m_a] = 0;
              m_a = m_o;
            end
      3'd7: if (m_lvl == 0) m_unf = 1; else begin
              if (m_a != m_r) m_used[m_a] = 0;
              if (m_o != m_a && m_o != m_r) m_used[m_o] = 0;
              m_lvl--;
              m_a = m_r; m_o = m_r;
              m_r = m_sfp[m_lvl]; m_rpc = m_spc[m_lvl];
            end
      default: ;
    endcase
  endtask

  task automatic push_exp(input string tag);
    exp_t e;
    e.due = cyc + 1;
    e.o = FW'(m_o); e.a = FW'(m_a); e.r = FW'(m_r);
    e.pc = m_rpc; e.ov = m_ovf; e.un = m_unf; e.tag = tag;
    q.push_back(e);
  endtask

  // driver
  task automatic do_op(input logic s, input logic [2:0] c, input logic [PW-1:0] pc, input string tag);
    @(negedge clk);
    step = s; chop = c; cur_pc = pc;
    if (s) model_step(c, pc);
    push_exp(tag);
    @(posedge clk);
    #1 step = 1'b0;
  endtask

  task automatic do_reset();
    wait (q.size() == 0);
    @(negedge clk);
    rst_n = 1'b0; step = 1'b0;
    repeat (2) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
    push_exp("R1 reset state");
  endtask

  // monitor
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (open_fp !== e.o || active_fp !== e.a || return_fp !== e.r ||
          ret_pc !== e.pc || ovf_flag !== e.ov || unf_flag !== e.un) begin
        errors++;
        $display("FAIL %s: got o=%0d a=%0d r=%0d pc=%0d ov=%0b un=%0b exp o=%0d a=%0d r=%0d pc=%0d ov=%0b un=%0b",
                 e.tag, open_fp, active_fp, return_fp, ret_pc, ovf_flag, unf_flag,
                 e.o, e.a, e.r, e.pc, e.ov, e.un);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset();
    // open, call, nested, return chain
    do_op(1, 3'd1, 8'd10, "R2 open allocates frame 1");
    do_op(1, 3'd4, 8'd20, "R3 call activates open frame");
    do_op(1, 3'd1, 8'd30, "R2 open allocates frame 2");
    do_op(1, 3'd4, 8'd40, "R3 nested call");
    do_op(1, 3'd7, 8'd0,  "R4 return restores pointers, ret_pc 41");
    do_op(1, 3'd1, 8'd0,  "R8 released frame 2 reused");
    do_op(1, 3'd7, 8'd0,  "R4 return to outer, ret_pc 21");
    // idle cases
    do_op(1, 3'd0, 8'd5,  "R9 nop no change");
    do_op(1, 3'd3, 8'd5,  "R9 spare code no change");
    do_op(0, 3'd4, 8'd5,  "R9 step low ignores call");
    do_op(0, 3'd1, 8'd5,  "R9 step low ignores open");
    // open-and-call chain
    do_op(1, 3'd5, 8'd50, "R5 open-call moves three pointers");
    do_op(1, 3'd5, 8'd60, "R5 second open-call");
    do_op(1, 3'd5, 8'd70, "R5 third open-call");
    do_op(1, 3'd7, 8'd0,  "R4 return after open-call");
    do_op(1, 3'd7, 8'd0,  "R4 second return after open-call");
    do_op(1, 3'd7, 8'd0,  "R4 third return after open-call");
    // tail forms
    do_op(1, 3'd1, 8'd0,  "R2 open before tail call");
    do_op(1, 3'd4, 8'd80, "R3 call before tail call");
    do_op(1, 3'd1, 8'd0,  "R2 open target of tail call");
    do_op(1, 3'd6, 8'd0,  "R7 tail call frees old active");
    do_op(1, 3'd1, 8'd0,  "R8 frame freed by tail call reused");
    do_op(1, 3'd2, 8'd0,  "R6 tail open reuses active, frees open");
    do_op(1, 3'd1, 8'd0,  "R8 frame freed by tail open reused");
    do_op(1, 3'd7, 8'd0,  "R4 return ret_pc 81");
    // wrap
    do_op(1, 3'd4, 8'hFF, "R12 call at all-ones pc");
    do_op(1, 3'd7, 8'd0,  "R12 return pc wraps to 0");
    // underflow
    do_op(1, 3'd7, 8'd0,  "R11 return on empty stack");
    do_op(1, 3'd1, 8'd0,  "R11 underflow flag stays after open");
    // stack overflow
    do_reset();
    for (int i = 0; i < DP; i++) do_op(1, 3'd4, PW'(100 + i), "R3 fill stack");
    do_op(1, 3'd4, 8'd120, "R10 call with full stack");
    do_op(1, 3'd5, 8'd121, "R10 open-call with full stack");
    do_op(1, 3'd7, 8'd0,   "R10 flag sticky after return");
    // frame exhaustion
    do_reset();
    for (int i = 0; i < NF - 1; i++) do_op(1, 3'd5, PW'(i), "R5 use up frames");
    do_op(1, 3'd5, 8'd200, "R10 open-call with no free frame");
    do_op(1, 3'd1, 8'd201, "R10 open with no free frame");
    do_op(1, 3'd7, 8'd0,   "R4 return after exhaustion");
    do_op(1, 3'd1, 8'd0,   "R8 allocation after return frees");
    wait (q.size() == 0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule